// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 8K x 8 Static RAM

This block lets synchronous logic read and write an external asynchronous static RAM organised as 8192 bytes. A single request (address, write flag, write data) is accepted while the controller is idle. The controller then sequences the memory's two chip selects (one active low, one active high), its active-low output enable and its active-low write enable. It returns read data together with a one-cycle completion pulse. The shared data bus is presented as separate in, out and driver-enable signals, so the pad ring can build the tristate.

All memory timing is expressed as clock-cycle counts in parameters. The integrator derives each count as the ceiling of the memory time divided by the clock period. Every operation begins and ends with the chip deselected, so the address bus only moves while the memory ignores it. A parameter selects one of two write styles. In the default style, output enable is raised for the whole write and a turnaround cycle keeps the two drivers from overlapping. In the other style, output enable stays low and the write pulse is stretched, so the memory's drivers have shut off before the controller drives.

Top module: `asram_ctrl`

## Requirements
- R1: After reset the chip is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_done`=0.
- R2: A request is taken only on a clock edge where `req_ready` is 1. `req_ready` is 1 only in the idle state, which is always deselected, and it stays 0 from acceptance until the completion cycle.
- R3: A read keeps the chip selected with `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_WAIT cycles. `rsp_done` is 1 in the cycle right after, and `rsp_rdata` then holds the byte the memory drove in the last wait cycle.
- R4: In the default style a write proceeds as follows. It spends one selected cycle with `mem_oe_n`=1, `mem_we_n`=1 and the drivers off. It then holds `mem_we_n`=0 for WR_PULSE cycles with the drivers on. It keeps the drivers on for one more cycle with `mem_we_n`=1. `rsp_done`=1 follows in the next cycle, with the chip deselected.
- R5: With KEEP_OE_WR=1, `mem_oe_n` stays 0 through the turnaround cycle and the pulse, and the pulse lasts WR_PULSE_OE cycles (at least 2). The drivers turn on only from the second pulse cycle, and `mem_oe_n` is 1 in the recovery cycle.
- R6: `mem_addr` never changes between two consecutive cycles in which the chip is selected.
- R7: `mem_dq_oe` is 1 only while the chip is selected and either `mem_oe_n`=1 or `mem_we_n`=0. The controller never drives while the memory may drive.
- R8: `rsp_done` is a single-cycle pulse, and `rsp_rdata` keeps its value until the next read completes.
- R9: A write changes only the addressed location. Reading back any address, including 0 and 8191, returns the last byte written there.
- R10: The chip is deselected in the completion cycle, so two operations are always separated by at least one deselected cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 13 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The assertions watch the bus rules on every cycle. They check that the drivers never overlap a possible memory read drive, that the address is stable while the chip is selected, that write enable falls only after a driver-off selected cycle, and that the drivers are released only once write enable is already high. They also check that completion is a single deselected cycle and that `req_ready` implies deselection. The exact length of each phase can only be shown by the bench's scenarios, which also cover the second write style and whether data truly lands in and returns from the memory. These scenarios sweep addresses across the whole range against a memory model in both styles and compare the results with arithmetic patterns.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD       = 3'd1,
        ST_WR_TA    = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_REC   = 3'd4
    } asram_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_ctr.sv
module asram_wait_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = cap ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int RD_WAIT     = 2,
    parameter int WR_PULSE    = 1,
    parameter int WR_PULSE_OE = 2,
    parameter int KEEP_OE_WR  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_LEN    = imax(RD_WAIT, 1);
    localparam int PULSE_LEN = (KEEP_OE_WR != 0) ? imax(WR_PULSE_OE, 2) : imax(WR_PULSE, 1);
    localparam int CW        = $clog2(imax(RD_LEN, PULSE_LEN) + 1);
    localparam logic OE_IN_WR = (KEEP_OE_WR != 0) ? 1'b0 : 1'b1;

    typedef struct packed {
        asram_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              cs;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              done;
    } regs_t;

    regs_t         r_d, r_q;
    logic          ctr_load;
    logic [CW-1:0] ctr_val;
    logic          ctr_last;
    logic          rd_cap;

    asram_wait_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .last     (ctr_last)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (rd_cap),
        .din   (mem_dq_in),
        .dout  (rsp_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctr_load = 1'b0;
        ctr_val  = '0;
        rd_cap   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.cs_n  = 1'b0;
                    r_d.cs    = 1'b1;
                    if (req_write) begin
                        r_d.st   = ST_WR_TA;
                        r_d.oe_n = OE_IN_WR;
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.oe_n = 1'b0;
                        ctr_load = 1'b1;
                        ctr_val  = CW'(RD_LEN - 1);
                    end
                end
            end
            ST_RD: begin
                if (ctr_last) begin
                    rd_cap   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    r_d.cs   = 1'b0;
                    r_d.oe_n = 1'b1;
                end
            end
            ST_WR_TA: begin
                r_d.st    = ST_WR_PULSE;
                r_d.we_n  = 1'b0;
                r_d.dq_oe = (KEEP_OE_WR == 0);
                ctr_load  = 1'b1;
                ctr_val   = CW'(PULSE_LEN - 1);
            end
            ST_WR_PULSE: begin
                r_d.dq_oe = 1'b1;
                if (ctr_last) begin
                    r_d.st   = ST_WR_REC;
                    r_d.we_n = 1'b1;
                    r_d.oe_n = 1'b1;
                end
            end
            ST_WR_REC: begin
                r_d.st    = ST_IDLE;
                r_d.dq_oe = 1'b0;
                r_d.done  = 1'b1;
                r_d.cs_n  = 1'b1;
                r_d.cs    = 1'b0;
                r_d.oe_n  = 1'b1;
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.cs_n  = 1'b1;
                r_d.cs    = 1'b0;
                r_d.oe_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_done   = r_q.done;
    assign mem_addr   = r_q.addr;
    assign mem_cs_n   = r_q.cs_n;
    assign mem_cs     = r_q.cs;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    logic sel;
    assign sel = !mem_cs_n && mem_cs;

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sel);

    assert_we_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(sel) && !$past(mem_dq_oe));

    assert_release_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> mem_we_n && $past(mem_we_n));

    assert_we_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> sel);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> sel && (mem_oe_n || !mem_we_n));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !sel);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int RDW = 2;
    localparam int WP  = 1;
    localparam int WPO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid [2];
    logic        req_write [2];
    logic [12:0] req_addr  [2];
    logic [7:0]  req_wdata [2];
    logic        req_ready [2];
    logic        rsp_done  [2];
    logic [7:0]  rsp_rdata [2];
    logic [12:0] m_addr    [2];
    logic        cs_n      [2];
    logic        cs        [2];
    logic        oe_n      [2];
    logic        we_n      [2];
    logic [7:0]  dq_out    [2];
    logic        dq_oe     [2];
    logic [7:0]  dq_in     [2];
    logic        sel       [2];

    int total = 0;
    int bad   = 0;

    for (genvar g = 0; g < 2; g++) begin : g_dut
        asram_ctrl #(.RD_WAIT(RDW), .WR_PULSE(WP), .WR_PULSE_OE(WPO), .KEEP_OE_WR(g)) dut_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[g]),
            .req_write  (req_write[g]),
            .req_addr   (req_addr[g]),
            .req_wdata  (req_wdata[g]),
            .req_ready  (req_ready[g]),
            .rsp_done   (rsp_done[g]),
            .rsp_rdata  (rsp_rdata[g]),
            .mem_addr   (m_addr[g]),
            .mem_cs_n   (cs_n[g]),
            .mem_cs     (cs[g]),
            .mem_oe_n   (oe_n[g]),
            .mem_we_n   (we_n[g]),
            .mem_dq_out (dq_out[g]),
            .mem_dq_oe  (dq_oe[g]),
            .mem_dq_in  (dq_in[g])
        );

        logic [7:0] mem [8192];
        initial begin
            for (int k = 0; k < 8192; k++) mem[k] = 8'hA5;
        end
        assign sel[g]   = !cs_n[g] && cs[g];
        assign dq_in[g] = (sel[g] && !oe_n[g] && we_n[g]) ? mem[m_addr[g]] : 8'h00;
        always @(negedge clk) begin
            if (sel[g] && !we_n[g] && dq_oe[g]) mem[m_addr[g]] <= dq_out[g];
        end
    end

    function automatic logic [7:0] pat(input int i, input int a);
        return 8'((a * 13 + (a >> 8) + i * 91) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input int i, input bit wr, input int a, input logic [7:0] d,
                          output logic [7:0] rd);
        int n = 0, n_oe = 0, n_we = 0, n_dq = 0;
        bit rdy_bad = 0, addr_bad = 0, cont_bad = 0;
        int e_cyc, e_oe, e_we, e_dq;
        @(negedge clk);
        while (!req_ready[i]) @(negedge clk);
        req_valid[i] = 1'b1;
        req_write[i] = wr;
        req_addr[i]  = 13'(a);
        req_wdata[i] = d;
        @(negedge clk);
        req_valid[i] = 1'b0;
        req_addr[i]  = ~13'(a);
        req_wdata[i] = ~d;
        while (n < 40) begin
            n++;
            if (sel[i] && !oe_n[i]) n_oe++;
            if (!we_n[i]) n_we++;
            if (dq_oe[i]) n_dq++;
            if (sel[i] && m_addr[i] != 13'(a)) addr_bad = 1;
            if (dq_oe[i] && sel[i] && !oe_n[i] && we_n[i]) cont_bad = 1;
            if (rsp_done[i]) break;
            if (req_ready[i]) rdy_bad = 1;
            @(negedge clk);
        end
        rd = rsp_rdata[i];
        if (!wr) begin
            e_cyc = RDW + 1; e_oe = RDW; e_we = 0; e_dq = 0;
        end else if (i == 0) begin
            e_cyc = WP + 3; e_oe = 0; e_we = WP; e_dq = WP + 1;
        end else begin
            e_cyc = WPO + 3; e_oe = WPO + 1; e_we = WPO; e_dq = WPO;
        end
        // R3 / R4 / R5: phase lengths
        chk(n == e_cyc, wr ? (i ? "R5 latency" : "R4 latency") : "R3 latency", n, e_cyc);
        chk(n_oe == e_oe, wr ? (i ? "R5 oe low" : "R4 oe high") : "R3 oe low", n_oe, e_oe);
        chk(n_we == e_we, wr ? (i ? "R5 pulse" : "R4 pulse") : "R3 we high", n_we, e_we);
        chk(n_dq == e_dq, wr ? (i ? "R5 drivers" : "R4 drivers") : "R7 drivers", n_dq, e_dq);
        chk(!rdy_bad, "R2 ready busy", rdy_bad, 0);
        chk(!addr_bad, "R6 addr", addr_bad, 0);
        chk(!cont_bad, "R7 contention", cont_bad, 0);
        chk(!sel[i], "R10 desel at done", sel[i], 0);
    endtask

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 2; i++) begin
            req_valid[i] = 0; req_write[i] = 0; req_addr[i] = '0; req_wdata[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            // R1 reset state
            chk(cs_n[i] && !cs[i], "R1 deselect", sel[i], 0);
            chk(we_n[i] && oe_n[i], "R1 strobes", {we_n[i], oe_n[i]}, 3);
            chk(!dq_oe[i], "R1 drivers", dq_oe[i], 0);
            chk(req_ready[i] && !rsp_done[i], "R1 ready", {req_ready[i], rsp_done[i]}, 2);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            for (int a = 0; a < 8192; a += 37) run_op(i, 1'b1, a, pat(i, a), rd);
            run_op(i, 1'b1, 8191, pat(i, 8191), rd);
            for (int a = 0; a < 8192; a += 37) begin
                run_op(i, 1'b0, a, 8'h00, rd);
                chk(rd == pat(i, a), "R9 readback", rd, pat(i, a));
            end
            run_op(i, 1'b0, 8191, 8'h00, rd);
            chk(rd == pat(i, 8191), "R9 top addr", rd, pat(i, 8191));
            run_op(i, 1'b0, 1, 8'h00, rd);
            chk(rd == 8'hA5, "R9 untouched", rd, 8'hA5);
            // R8: done single pulse, rdata held
            @(negedge clk);
            chk(!rsp_done[i], "R8 done pulse", rsp_done[i], 0);
            repeat (3) @(negedge clk);
            chk(rsp_rdata[i] == 8'hA5, "R8 rdata hold", rsp_rdata[i], 8'hA5);
            chk(req_ready[i] && !sel[i], "R2 idle ready", req_ready[i], 1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule